// File: doc/BRIEF.md
# Parallel-to-Serial Pixel Port Multiplexer

This block sits between a wide, slow frame-buffer port and a display DAC path running at the pixel clock. Once per group it captures a parallel word holding up to four 24-bit pixels in lanes A to D, together with the blank, sync and field-parity sideband bits. It then presents one pixel per pixel-clock cycle, with a valid strobe. The number of pixels per group is set by a two-bit ratio code.

Four ratios are supported. In 1:1, 2:1 and 4:1 the block sends whole true-colour lanes. In 8:1 it sends 8-bit pseudo-colour indices taken from the green and red bytes of every lane, and this ratio forces index output whatever the colour-mode input says.

The block runs entirely in the pixel-clock domain. It generates its own load strobe, one cycle per group, which is normally wired back to the load input. Sideband bits travel through the same two-cycle delay as the pixels, so each group's sideband stays aligned with that group's pixels and can only change on a group boundary.

Top module: `pxmux_serial_top`

## Requirements
- R1: The ratio code `mode_sel` selects the group length: 00 is 1:1, 01 is 2:1, 11 is 4:1 and 10 is 8:1. The code is sampled only at the clock edge where `load_out` becomes asserted, and it sets the length of the group period that starts there.
- R2: `load_out` is high for exactly one cycle in every N cycles, where N is the current group length. In 1:1 it stays high. After reset is released, the first clock edge asserts it.
- R3: At every clock edge where `load_in` is high, the block captures `pix_word`, the three sideband inputs and `index_mode` for the new group, using the group length that `load_out` started.
- R4: In 4:1, pixels leave in lane order A, B, C, D. Lane A is `pix_word[23:0]`, lane B is `[47:24]`, lane C is `[71:48]` and lane D is `[95:72]`.
- R5: In 2:1 only lane A and then lane B are sent. In 1:1 only lane A is sent.
- R6: In 8:1 the eight outputs are green A, red A, green B, red B, green C, red C, green D, red D. Within a lane, red is bits [23:16] and green is bits [15:8]. Each output has `pix_out[23:8]` at zero and `pix_is_index` at 1, whatever the value of `index_mode`.
- R7: In 1:1, 2:1 and 4:1 with `index_mode` captured as 1, each output is the lane's red byte on `pix_out[7:0]`, with zeros above it and `pix_is_index` at 1. With `index_mode` at 0, the whole lane is sent and `pix_is_index` is 0.
- R8: Pixel k of a group captured at edge c is presented with `pix_valid` high after edge c+2+k. In any cycle that carries no pixel, `pix_valid` is low.
- R9: The blank, sync and field outputs present the values captured with a group from edge c+2 through edge c+N+1, so they match every pixel of that group.
- R10: While reset is held, `pix_valid`, `load_out`, `pix_out`, `pix_is_index` and the sideband outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Ratio code (see R1) |
| index_mode | input | 1 | Colour mode requests 8-bit index output |
| load_in | input | 1 | Load qualifier; a group is captured at edges where it is high |
| pix_word | input | 96 | Four 24-bit lanes, A in the low bits |
| blank_in | input | 1 | Blanking sideband |
| sync_in | input | 1 | Sync sideband |
| field_in | input | 1 | Field-parity sideband |
| load_out | output | 1 | Generated load strobe, one cycle per group |
| pix_out | output | 24 | Serialised pixel or zero-extended index |
| pix_is_index | output | 1 | Output is an 8-bit index |
| pix_valid | output | 1 | Output pixel is valid |
| blank_out | output | 1 | Aligned blanking |
| sync_out | output | 1 | Aligned sync |
| field_out | output | 1 | Aligned field parity |

## Verification
The assertions assume that `load_in` follows `load_out`. With that wiring, loads arrive exactly one group apart, so no group is cut short and the first-pixel check always has a load behind it. The bench keeps to this assumption by tying `load_in` to `load_out` permanently. It still changes the ratio code and `index_mode` in arbitrary cycles, so boundary sampling is exercised on every edge. The pixel word and the sideband bits change every cycle, so any capture outside the load edge would corrupt the expected values.

// File: rtl/pxmux_pkg.sv
package pxmux_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_CHAN_W = 8;
    localparam int SB_W       = 3;

    typedef enum logic [1:0] {
        RATIO_1 = 2'b00,
        RATIO_2 = 2'b01,
        RATIO_8 = 2'b10,
        RATIO_4 = 2'b11
    } ratio_e;

    // pixels emitted per load period for a ratio code
    function automatic int group_len(ratio_e r, int lanes);
        case (r)
            RATIO_2: return 2;
            RATIO_4: return lanes;
            RATIO_8: return 2 * lanes;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/pxmux_load_div.sv
module pxmux_load_div
    import pxmux_pkg::*;
#(
    parameter int LANE_CNT = DEF_LANES
) (
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_e mode_i,
    output logic   load_o,
    output ratio_e ratio_o
);
    localparam int CNT_W = $clog2(2 * LANE_CNT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             load;
        ratio_e           ratio;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if ((int'(st_q.cnt) + 1) >= group_len(st_q.ratio, LANE_CNT)) begin
            st_d.cnt   = '0;
            st_d.load  = 1'b1;
            st_d.ratio = mode_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.load  <= 1'b0;
            st_q.ratio <= RATIO_1;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o  = st_q.load;
    assign ratio_o = st_q.ratio;

    // R1: the latched ratio only moves when a new period begins
    p_ratio_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ratio != $past(st_q.ratio)) |-> st_q.load);

    // R2: a strobe in a multi-pixel period lasts one cycle
    p_load_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load && st_q.ratio != RATIO_1) |=> !st_q.load);

endmodule

// File: rtl/pxmux_capture.sv
module pxmux_capture
    import pxmux_pkg::*;
#(
    parameter int WORD_W = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [SB_W-1:0]   sb_i,
    input  logic              index_i,
    input  ratio_e            ratio_i,
    output logic [WORD_W-1:0] word_o,
    output logic [SB_W-1:0]   sb_o,
    output logic              index_o,
    output ratio_e            ratio_o,
    output logic              start_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [SB_W-1:0]   sb;
        logic              index;
        ratio_e            ratio;
        logic              start;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = load_i;
        if (load_i) begin
            st_d.word  = word_i;
            st_d.sb    = sb_i;
            st_d.index = index_i;
            st_d.ratio = ratio_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word  <= '0;
            st_q.sb    <= '0;
            st_q.index <= 1'b0;
            st_q.ratio <= RATIO_1;
            st_q.start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.word;
    assign sb_o    = st_q.sb;
    assign index_o = st_q.index;
    assign ratio_o = st_q.ratio;
    assign start_o = st_q.start;

    // R3: the held word is the one present at the load edge
    p_capture_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.word == $past(word_i)));

endmodule

// File: rtl/pxmux_lane_ser.sv
module pxmux_lane_ser
    import pxmux_pkg::*;
#(
    parameter int LANE_CNT = DEF_LANES,
    parameter int CHAN_W   = DEF_CHAN_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LANE_CNT*3*CHAN_W-1:0]   word_i,
    input  ratio_e                         ratio_i,
    input  logic                           index_i,
    input  logic                           start_i,
    output logic [3*CHAN_W-1:0]            pix_o,
    output logic                           is_index_o,
    output logic                           valid_o
);
    localparam int PIXEL_W = 3 * CHAN_W;
    localparam int SEL_W   = $clog2(2 * LANE_CNT);
    localparam int LANE_W  = SEL_W - 1;
    localparam int REM_W   = $clog2(2 * LANE_CNT + 1);

    logic [PIXEL_W-1:0] lane_a [LANE_CNT];
    logic [CHAN_W-1:0]  red_a  [LANE_CNT];
    logic [CHAN_W-1:0]  grn_a  [LANE_CNT];

    for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
        assign lane_a[l] = word_i[l*PIXEL_W +: PIXEL_W];
        assign red_a[l]  = lane_a[l][3*CHAN_W-1 -: CHAN_W];
        assign grn_a[l]  = lane_a[l][2*CHAN_W-1 -: CHAN_W];
    end

    typedef struct packed {
        logic [SEL_W-1:0]   idx;
        logic [REM_W-1:0]   rem;
        logic [PIXEL_W-1:0] pix;
        logic               isi;
        logic               vld;
    } ser_t;

    ser_t             st_d, st_q;
    logic [SEL_W-1:0] sel;
    logic [CHAN_W-1:0] byte_pick;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        sel       = start_i ? '0 : st_q.idx;
        byte_pick = sel[0] ? red_a[sel[SEL_W-1:1]] : grn_a[sel[SEL_W-1:1]];
        if (start_i || st_q.rem != '0) begin
            st_d.vld = 1'b1;
            if (ratio_i == RATIO_8) begin
                st_d.pix = {{(PIXEL_W-CHAN_W){1'b0}}, byte_pick};
                st_d.isi = 1'b1;
            end else if (index_i) begin
                st_d.pix = {{(PIXEL_W-CHAN_W){1'b0}}, red_a[sel[LANE_W-1:0]]};
                st_d.isi = 1'b1;
            end else begin
                st_d.pix = lane_a[sel[LANE_W-1:0]];
                st_d.isi = 1'b0;
            end
            st_d.idx = sel + 1'b1;
            if (start_i) begin
                st_d.rem = REM_W'(group_len(ratio_i, LANE_CNT) - 1);
            end else begin
                st_d.rem = st_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o      = st_q.pix;
    assign is_index_o = st_q.isi;
    assign valid_o    = st_q.vld;

    // R7: an index output never carries bits above the byte
    p_index_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.isi) |-> (st_q.pix[PIXEL_W-1:CHAN_W] == '0));

    // R6: an 8:1 group always yields index pixels
    p_pseudo_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ratio_i == RATIO_8) |=> (st_q.vld && st_q.isi));

endmodule

// File: rtl/pxmux_serial_top.sv
module pxmux_serial_top
    import pxmux_pkg::*;
#(
    parameter int LANE_CNT = DEF_LANES,
    parameter int CHAN_W   = DEF_CHAN_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode_sel,
    input  logic                          index_mode,
    input  logic                          load_in,
    input  logic [LANE_CNT*3*CHAN_W-1:0]  pix_word,
    input  logic                          blank_in,
    input  logic                          sync_in,
    input  logic                          field_in,
    output logic                          load_out,
    output logic [3*CHAN_W-1:0]           pix_out,
    output logic                          pix_is_index,
    output logic                          pix_valid,
    output logic                          blank_out,
    output logic                          sync_out,
    output logic                          field_out
);
    localparam int PIXEL_W = 3 * CHAN_W;
    localparam int WORD_W  = LANE_CNT * PIXEL_W;

    ratio_e             div_ratio, grp_ratio;
    logic [WORD_W-1:0]  grp_word;
    logic [SB_W-1:0]    grp_sb;
    logic               grp_index, grp_start;
    logic [PIXEL_W-1:0] ser_pix;
    logic               ser_isi, ser_vld;

    pxmux_load_div #(.LANE_CNT(LANE_CNT)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (ratio_e'(mode_sel)),
        .load_o  (load_out),
        .ratio_o (div_ratio)
    );

    pxmux_capture #(.WORD_W(WORD_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_in),
        .word_i  (pix_word),
        .sb_i    ({field_in, sync_in, blank_in}),
        .index_i (index_mode),
        .ratio_i (div_ratio),
        .word_o  (grp_word),
        .sb_o    (grp_sb),
        .index_o (grp_index),
        .ratio_o (grp_ratio),
        .start_o (grp_start)
    );

    pxmux_lane_ser #(.LANE_CNT(LANE_CNT), .CHAN_W(CHAN_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (grp_word),
        .ratio_i    (grp_ratio),
        .index_i    (grp_index),
        .start_i    (grp_start),
        .pix_o      (ser_pix),
        .is_index_o (ser_isi),
        .valid_o    (ser_vld)
    );

    typedef struct packed {
        logic [PIXEL_W-1:0] pix;
        logic               isi;
        logic               vld;
        logic [SB_W-1:0]    sb_mid;
        logic [SB_W-1:0]    sb;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pix    = ser_pix;
        st_d.isi    = ser_isi;
        st_d.vld    = ser_vld;
        st_d.sb_mid = grp_sb;
        st_d.sb     = st_q.sb_mid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_out      = st_q.pix;
    assign pix_is_index = st_q.isi;
    assign pix_valid    = st_q.vld;
    assign blank_out    = st_q.sb[0];
    assign sync_out     = st_q.sb[1];
    assign field_out    = st_q.sb[2];

    // R8: a load is followed by a valid pixel two clocks later
    p_first_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_in |-> ##3 pix_valid);

endmodule

// File: tb/pxmux_serial_top_tb.sv
module pxmux_serial_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_sel;
    logic        index_mode;
    logic        load_in;
    logic [95:0] pix_word;
    logic        blank_in, sync_in, field_in;
    logic        load_out;
    logic [23:0] pix_out;
    logic        pix_is_index, pix_valid;
    logic        blank_out, sync_out, field_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign load_in = load_out;

    pxmux_serial_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .index_mode(index_mode),
        .load_in(load_in), .pix_word(pix_word), .blank_in(blank_in),
        .sync_in(sync_in), .field_in(field_in), .load_out(load_out),
        .pix_out(pix_out), .pix_is_index(pix_is_index), .pix_valid(pix_valid),
        .blank_out(blank_out), .sync_out(sync_out), .field_out(field_out)
    );

    // expectation ring indexed by edge number
    logic        sl_v   [32];
    logic [24:0] sl_pix [32];
    logic [2:0]  sl_sb  [32];
    string       sl_tag [32];

    int         edge_n, next_wrap, period_n;
    logic [1:0] drv_mode;

    function automatic int len_of(logic [1:0] c);
        case (c)
            2'b01: return 2;
            2'b11: return 4;
            2'b10: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [24:0] exp_pix(logic [95:0] w, logic [1:0] c, logic im, int k);
        logic [23:0] ln;
        logic [7:0]  b;
        if (c == 2'b10) begin
            ln = w[(k/2)*24 +: 24];
            b  = (k % 2 == 1) ? ln[23:16] : ln[15:8];
            return {1'b1, 16'h0, b};
        end
        ln = w[k*24 +: 24];
        if (im) return {1'b1, 16'h0, ln[23:16]};
        return {1'b0, ln};
    endfunction

    function automatic string tag_of(logic [1:0] c, logic im);
        if (c == 2'b10) return "R6 R3 R1";
        if (im)         return "R7 R3 R1";
        if (c == 2'b11) return "R4 R3 R1";
        return "R5 R3 R1";
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at edge %0d: act %h exp %h", req, edge_n, act, exp);
        end
    endtask

    task automatic step(logic [1:0] m_new, logic im_new, int pat);
        bit exp_load;
        int s;
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        exp_load = (edge_n == next_wrap);
        if (exp_load) begin
            period_n  = len_of(drv_mode);
            next_wrap = edge_n + period_n;
        end
        chk(load_out == exp_load, "R2", 64'(load_out), 64'(exp_load));
        s = edge_n % 32;
        if (sl_v[s]) begin
            chk(pix_valid == 1'b1, "R8", 64'(pix_valid), 64'd1);
            chk({pix_is_index, pix_out} == sl_pix[s], sl_tag[s],
                64'({pix_is_index, pix_out}), 64'(sl_pix[s]));
            chk({field_out, sync_out, blank_out} == sl_sb[s], "R9",
                64'({field_out, sync_out, blank_out}), 64'(sl_sb[s]));
            sl_v[s] = 1'b0;
        end else begin
            chk(pix_valid == 1'b0, "R8", 64'(pix_valid), 64'd0);
        end
        // drive inputs for the next edge
        case (pat)
            1: pix_word = '1;
            2: pix_word = 96'h0;
            default: pix_word = {$urandom, $urandom, $urandom};
        endcase
        {field_in, sync_in, blank_in} = 3'($urandom);
        mode_sel   = m_new;
        index_mode = im_new;
        if (exp_load) begin
            for (int k = 0; k < period_n; k++) begin
                int t = (edge_n + 3 + k) % 32;
                sl_v[t]   = 1'b1;
                sl_pix[t] = exp_pix(pix_word, drv_mode_grp, index_mode, k);
                sl_sb[t]  = {field_in, sync_in, blank_in};
                sl_tag[t] = tag_of(drv_mode_grp, index_mode);
            end
        end
        drv_mode = m_new;
    endtask

    logic [1:0] drv_mode_grp;
    always_comb drv_mode_grp = grp_code_hold;
    logic [1:0] grp_code_hold;

    task automatic run(int n, logic [1:0] m, logic im, int pat);
        for (int i = 0; i < n; i++) begin
            if (edge_n + 1 == next_wrap) grp_code_hold = drv_mode;
            step(m, im, pat);
        end
    endtask

    task automatic run_rand(int n);
        logic [1:0] m;
        logic       im;
        m  = 2'b00;
        im = 1'b0;
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(5) == 0) m  = 2'($urandom);
            if ($urandom_range(7) == 0) im = 1'($urandom);
            if (edge_n + 1 == next_wrap) grp_code_hold = drv_mode;
            step(m, im, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 32; i++) begin
            sl_v[i] = 1'b0; sl_pix[i] = '0; sl_sb[i] = '0; sl_tag[i] = "";
        end
        rst_n = 1'b0;
        mode_sel = 2'b00; index_mode = 1'b0; pix_word = '0;
        blank_in = 1'b0; sync_in = 1'b0; field_in = 1'b0;
        grp_code_hold = 2'b00;
        edge_n = 0; next_wrap = 1; period_n = 1;
        repeat (3) @(negedge clk);
        // R10: quiet outputs while in reset
        chk({pix_valid, load_out, pix_is_index, pix_out, field_out, sync_out, blank_out} == '0,
            "R10", 64'({pix_valid, load_out, pix_is_index, pix_out, field_out, sync_out, blank_out}), 64'd0);
        drv_mode = 2'b11;
        mode_sel = 2'b11;
        rst_n    = 1'b1;
        run(40, 2'b11, 1'b0, 0);   // R4 lane order
        run(30, 2'b01, 1'b0, 0);   // R5 two lanes
        run(20, 2'b00, 1'b0, 0);   // R5 single lane
        run(48, 2'b10, 1'b0, 0);   // R6 byte interleave
        run(24, 2'b10, 1'b1, 1);   // R6 all-ones word, index flag ignored
        run(24, 2'b10, 1'b0, 2);   // R6 all-zero word
        run(32, 2'b11, 1'b1, 0);   // R7 red byte index
        run(16, 2'b01, 1'b1, 0);   // R7 in 2:1
        run(16, 2'b00, 1'b1, 0);   // R7 in 1:1
        run(20, 2'b01, 1'b0, 1);   // R1 back-to-back mode changes
        run(3,  2'b10, 1'b0, 0);
        run(3,  2'b00, 1'b0, 0);
        run_rand(1500);            // R1 R8 R9 random mode flips
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: act running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule